// File: doc/BRIEF.md
# Rotate-and-Mask Execution Unit

This unit executes a single fixed-point instruction: rotate a 32-bit source operand left by an immediate amount, then AND the rotated word with a contiguous (or wrapped) mask described by a start and a stop bit position. It takes the raw 32-bit instruction word and the source operand value. It decodes the fields itself and returns the result together with the destination register index. It also echoes the source register index so the issue logic can match operands.

When the instruction's record bit is set, the unit also produces a 4-bit condition field. The field compares the signed result with zero and carries the incoming summary-overflow flag. A word whose major opcode is not the rotate-and-mask opcode is flagged as illegal and requests neither a register write nor a condition update. The datapath is combinational and ends in one optional output register, so with the default setting a result appears one clock after it is accepted.

Top module: `rotmask_unit`

## Requirements
- R1: Instruction fields are numbered with bit 0 as the most significant bit. The major opcode is bits 0-5, the source index is bits 6-10, the destination index is bits 11-15, the rotate count is bits 16-20, the mask start is bits 21-25, the mask stop is bits 26-30 and the record flag is bit 31. `out_dest` and `out_src_idx` carry the destination and source fields.
- R2: The result equals the source operand rotated left by the rotate count (0 to 31), ANDed with the generated mask.
- R3: When the mask start is less than or equal to the mask stop, the mask has ones at positions start through stop and zeros elsewhere. Position p is word bit 31-p. For example, start 0 and stop 29 gives 0xFFFFFFFC.
- R4: When the mask start is greater than the mask stop, the mask has ones from start through position 31 and from position 0 through stop, with zeros between them.
- R5: With the record flag at 1 on a legal word, `out_cond_wr` is 1 and `out_cond` is {LT, GT, EQ, SO} with LT as bit 3. LT, GT and EQ compare the result as a signed 32-bit value with zero, and SO is a copy of `in_so`.
- R6: With the record flag at 0, `out_cond_wr` is 0 and `out_cond` is 0.
- R7: A word whose opcode is not 21 sets `out_illegal`, and gives `out_wr_en`=0, `out_cond_wr`=0 and `out_result`=0.
- R8: With the output register enabled, `out_valid` and all results appear on the clock edge after the one where `in_valid` was sampled high.
- R9: During and right after reset, all outputs are 0.
- R10: A cycle with `in_valid` low gives `out_valid`, `out_wr_en`, `out_cond_wr` and `out_illegal` all 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and instruction word are valid this cycle |
| in_insn | input | 32 | Instruction word |
| in_src | input | 32 | Source operand value |
| in_so | input | 1 | Current summary-overflow flag |
| out_valid | output | 1 | Output slot holds an executed word |
| out_wr_en | output | 1 | Write `out_result` to register `out_dest` |
| out_dest | output | 5 | Destination register index |
| out_src_idx | output | 5 | Source register index from the word |
| out_result | output | 32 | Rotated and masked result |
| out_cond_wr | output | 1 | Update the condition field |
| out_cond | output | 4 | Condition field {LT, GT, EQ, SO} |
| out_illegal | output | 1 | Opcode was not the rotate-and-mask opcode |

## Verification
The bench builds the unit with its default values: the output register enabled and the opcode set to 21. With these values the one-cycle latency and the reset values of the registered outputs can be observed. Directed words cover both worked examples, wrapped and single-bit masks, a full mask with zero rotation, and zero, positive and negative results with and without the overflow flag. A long random run then mixes illegal opcodes, idle cycles and every start/stop ordering, and each output is compared with a behavioural model on every clock.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;
    localparam int WORD_W = 32;
    localparam int OPC_W  = 6;
    localparam int IDX_W  = 5;
    localparam int SH_W   = $clog2(WORD_W);
    localparam int CR_W   = 4;

    // Packed in the order the fields occupy the word, most significant first.
    typedef struct packed {
        logic [OPC_W-1:0] opcd;
        logic [IDX_W-1:0] src_idx;
        logic [IDX_W-1:0] dst_idx;
        logic [SH_W-1:0]  rot;
        logic [SH_W-1:0]  mbeg;
        logic [SH_W-1:0]  mend;
        logic             rec;
    } insn_t;

    typedef struct packed {
        logic              vld;
        logic              wr;
        logic [IDX_W-1:0]  dst;
        logic [IDX_W-1:0]  src;
        logic [WORD_W-1:0] res;
        logic [CR_W-1:0]   cr;
        logic              cr_wr;
        logic              ill;
    } stage_t;
endpackage

// File: rtl/rotmask_decode.sv
module rotmask_decode
    import rotmask_pkg::*;
#(
    parameter int OPCODE = 21
) (
    input  logic [WORD_W-1:0] insn_word,
    output insn_t             fields,
    output logic              legal
);
    always_comb begin
        fields = insn_t'(insn_word);
        legal  = (fields.opcd == OPC_W'(OPCODE));
    end
endmodule

// File: rtl/rotmask_rotator.sv
module rotmask_rotator #(
    parameter int W = 32,
    localparam int LG = $clog2(W)
) (
    input  logic [W-1:0]  data_in,
    input  logic [LG-1:0] amount,
    output logic [W-1:0]  data_out
);
    logic [W-1:0] stage [0:LG];

    assign stage[0] = data_in;

    for (genvar k = 0; k < LG; k++) begin : g_stage
        localparam int AMT = 1 << k;
        assign stage[k+1] = amount[k]
            ? {stage[k][W-1-AMT:0], stage[k][W-1 -: AMT]}
            : stage[k];
    end

    assign data_out = stage[LG];
endmodule

// File: rtl/rotmask_maskgen.sv
module rotmask_maskgen #(
    parameter int W = 32,
    localparam int LG = $clog2(W)
) (
    input  logic [LG-1:0] start_pos,
    input  logic [LG-1:0] stop_pos,
    output logic [W-1:0]  mask
);
    logic wrap;
    assign wrap = (start_pos > stop_pos);

    // Position p (most significant first) maps to word bit W-1-p.
    for (genvar p = 0; p < W; p++) begin : g_pos
        logic at_or_after;
        logic at_or_before;
        assign at_or_after  = (LG'(p) >= start_pos);
        assign at_or_before = (LG'(p) <= stop_pos);
        assign mask[W-1-p]  = wrap ? (at_or_after | at_or_before)
                                   : (at_or_after & at_or_before);
    end
endmodule

// File: rtl/rotmask_cond.sv
module rotmask_cond #(
    parameter int W = 32
) (
    input  logic [W-1:0] value,
    input  logic         so_in,
    output logic [3:0]   cr
);
    logic lt, eq, gt;
    always_comb begin
        lt = value[W-1];
        eq = (value == '0);
        gt = !lt && !eq;
        cr = {lt, gt, eq, so_in};
    end
endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit
    import rotmask_pkg::*;
#(
    parameter int OPCODE  = 21,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_insn,
    input  logic [WORD_W-1:0] in_src,
    input  logic              in_so,
    output logic              out_valid,
    output logic              out_wr_en,
    output logic [IDX_W-1:0]  out_dest,
    output logic [IDX_W-1:0]  out_src_idx,
    output logic [WORD_W-1:0] out_result,
    output logic              out_cond_wr,
    output logic [CR_W-1:0]   out_cond,
    output logic              out_illegal
);
    insn_t             dec;
    logic              legal;
    logic [WORD_W-1:0] rotated;
    logic [WORD_W-1:0] mask;
    logic [WORD_W-1:0] masked;
    logic [CR_W-1:0]   cr_calc;
    stage_t            stage_d, stage_q;

    rotmask_decode #(.OPCODE(OPCODE)) u_dec (
        .insn_word (in_insn),
        .fields    (dec),
        .legal     (legal)
    );

    rotmask_rotator #(.W(WORD_W)) u_rot (
        .data_in  (in_src),
        .amount   (dec.rot),
        .data_out (rotated)
    );

    rotmask_maskgen #(.W(WORD_W)) u_mask (
        .start_pos (dec.mbeg),
        .stop_pos  (dec.mend),
        .mask      (mask)
    );

    assign masked = rotated & mask;

    rotmask_cond #(.W(WORD_W)) u_cond (
        .value (masked),
        .so_in (in_so),
        .cr    (cr_calc)
    );

    always_comb begin
        stage_d = '0;
        if (in_valid) begin
            stage_d.vld = 1'b1;
            stage_d.dst = dec.dst_idx;
            stage_d.src = dec.src_idx;
            stage_d.ill = !legal;
            if (legal) begin
                stage_d.wr    = 1'b1;
                stage_d.res   = masked;
                stage_d.cr_wr = dec.rec;
                stage_d.cr    = dec.rec ? cr_calc : '0;
            end
        end
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= '0;
            else        stage_q <= stage_d;
        end
    end else begin : g_comb
        assign stage_q = stage_d;
    end

    assign out_valid   = stage_q.vld;
    assign out_wr_en   = stage_q.wr;
    assign out_dest    = stage_q.dst;
    assign out_src_idx = stage_q.src;
    assign out_result  = stage_q.res;
    assign out_cond_wr = stage_q.cr_wr;
    assign out_cond    = stage_q.cr;
    assign out_illegal = stage_q.ill;

    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (!out_wr_en && !out_cond_wr && out_result == '0)); // R7
    AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        out_cond_wr |-> ($countones(out_cond[3:1]) == 1)); // R5
    AST_NOREC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (out_wr_en && !out_cond_wr) |-> (out_cond == '0)); // R6

    if (REG_OUT) begin : g_seq_chk
        AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid); // R8
        AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> (!out_valid && !out_wr_en && !out_cond_wr && !out_illegal)); // R10
        AST_DEST_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (out_dest == $past(in_insn[20:16]))); // R1
        AST_SO_COPY: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_insn[0] && in_insn[31:26] == OPC_W'(OPCODE))
                |=> (out_cond_wr && out_cond[0] == $past(in_so))); // R5
    end
endmodule

// File: tb/rotmask_unit_tb_top.sv
module rotmask_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_insn = '0;
    logic [31:0] in_src = '0;
    logic        in_so = 1'b0;
    logic        out_valid, out_wr_en, out_cond_wr, out_illegal;
    logic [4:0]  out_dest, out_src_idx;
    logic [31:0] out_result;
    logic [3:0]  out_cond;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        bit          vld, wr, cr_wr, ill;
        logic [4:0]  dst, src;
        logic [31:0] res;
        logic [3:0]  cr;
        bit          wrapped;
    } exp_t;

    exp_t pending;

    always #10 clk = ~clk;

    rotmask_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
        .in_src(in_src), .in_so(in_so), .out_valid(out_valid),
        .out_wr_en(out_wr_en), .out_dest(out_dest), .out_src_idx(out_src_idx),
        .out_result(out_result), .out_cond_wr(out_cond_wr), .out_cond(out_cond),
        .out_illegal(out_illegal)
    );

    function automatic logic [31:0] mk(int op, int rs, int ra, int sh, int mb, int me, int rc);
        return {6'(op), 5'(rs), 5'(ra), 5'(sh), 5'(mb), 5'(me), 1'(rc)};
    endfunction

    function automatic exp_t model(bit v, logic [31:0] w, logic [31:0] s, bit so);
        exp_t e;
        int sh, mb, me;
        logic [31:0] rot, msk;
        e = '{default: 0};
        if (!v) return e;
        sh = int'(w[15:11]); mb = int'(w[10:6]); me = int'(w[5:1]);
        e.vld = 1; e.dst = w[20:16]; e.src = w[25:21];
        e.wrapped = (mb > me);
        if (w[31:26] != 6'd21) begin
            e.ill = 1;
            return e;
        end
        for (int i = 0; i < 32; i++) rot[(i + sh) % 32] = s[i];
        for (int p = 0; p < 32; p++)
            msk[31-p] = (mb <= me) ? (p >= mb && p <= me) : (p >= mb || p <= me);
        e.wr  = 1;
        e.res = rot & msk;
        if (w[0]) begin
            e.cr_wr = 1;
            e.cr = {$signed(e.res) < 0, $signed(e.res) > 0, e.res == 0, so};
        end
        return e;
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual 0x%08h expected 0x%08h", tag, $time, act, expv);
        end
    endtask

    task automatic compare();
        chk(out_valid == pending.vld, "R8 out_valid", 32'(out_valid), 32'(pending.vld));
        chk(out_wr_en == pending.wr, "R7/R10 out_wr_en", 32'(out_wr_en), 32'(pending.wr));
        chk(out_illegal == pending.ill, "R7 out_illegal", 32'(out_illegal), 32'(pending.ill));
        chk(out_dest == pending.dst, "R1 out_dest", 32'(out_dest), 32'(pending.dst));
        chk(out_src_idx == pending.src, "R1 out_src_idx", 32'(out_src_idx), 32'(pending.src));
        chk(out_result == pending.res, pending.wrapped ? "R2,R4 out_result" : "R2,R3 out_result",
            out_result, pending.res);
        chk(out_cond_wr == pending.cr_wr, "R6 out_cond_wr", 32'(out_cond_wr), 32'(pending.cr_wr));
        chk(out_cond == pending.cr, "R5 out_cond", 32'(out_cond), 32'(pending.cr));
    endtask

    // One clock: check the previous cycle's outputs, then drive the next inputs.
    task automatic step(bit v, logic [31:0] w, logic [31:0] s, bit so);
        @(negedge clk);
        compare();
        in_valid = v; in_insn = w; in_src = s; in_so = so;
        pending = model(v, w, s, so);
    endtask

    initial begin
        pending = '{default: 0};
        repeat (3) begin
            @(negedge clk);
            chk({out_valid, out_wr_en, out_cond_wr, out_illegal} == 4'b0 && out_result == 0,
                "R9 reset outputs", out_result, 32'h0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && out_cond == 0, "R9 after reset", 32'(out_valid), 32'h0);

        // Worked examples
        step(1, mk(21, 4, 6, 2, 0, 29, 0), 32'h9000_3000, 0);
        step(1, mk(21, 4, 6, 2, 0, 29, 1), 32'hB004_3000, 0);
        @(negedge clk);
        chk(out_result == 32'hC010_C000, "R2 example result", out_result, 32'hC010_C000);
        chk(out_cond == 4'h8, "R5 example cond", 32'(out_cond), 32'h8);
        compare();
        in_valid = 0;
        pending = model(0, 0, 0, 0);
        // Wrapped mask: start 30, stop 1 -> ones at 31..30 and 1..0 (word bits)
        step(1, mk(21, 1, 2, 0, 30, 1, 0), 32'hFFFF_FFFF, 0);
        @(negedge clk);
        chk(out_result == 32'hC000_0003, "R4 wrapped mask", out_result, 32'hC000_0003);
        compare();
        in_valid = 0;
        pending = model(0, 0, 0, 0);
        // Idle then check R10
        step(0, mk(21, 3, 3, 3, 3, 3, 1), 32'h1234_5678, 1);
        step(1, mk(21, 7, 9, 0, 0, 31, 1), 32'h0000_0000, 1);   // EQ with SO
        step(1, mk(21, 7, 9, 0, 0, 31, 1), 32'h0000_0005, 0);   // GT
        step(1, mk(21, 7, 9, 31, 0, 31, 1), 32'h0000_0001, 1);  // LT, rotate 31
        step(1, mk(21, 7, 9, 5, 13, 13, 1), 32'hFFFF_FFFF, 0);  // single bit
        step(1, mk(20, 7, 9, 5, 0, 31, 1), 32'hFFFF_FFFF, 1);   // illegal R7
        step(1, mk(63, 1, 2, 1, 4, 2, 0), 32'hDEAD_BEEF, 0);    // illegal
        step(1, mk(21, 1, 2, 0, 31, 0, 0), 32'hFFFF_FFFF, 0);   // wrap edges R4
        step(1, mk(21, 1, 2, 16, 8, 23, 0), 32'hA5A5_0F0F, 1);  // R3, no record R6
        step(0, 0, 0, 0);

        for (int i = 0; i < 2000; i++) begin
            logic [31:0] w;
            w = $urandom;
            if ($urandom % 8 != 0) w[31:26] = 6'd21;
            step(($urandom % 6) != 0, w, $urandom, 1'($urandom));
        end
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule